// File: doc/BRIEF.md
# Edge-Activated DMA Request Sequencer

This block turns each falling edge on an active-low external request pin into exactly one block transfer. A block is a run of alternating read and write bus cycles, one byte per pair, followed by a single dead cycle. The request pin is sampled on every rising clock edge. A low sample taken while acceptance is open is held as a pending request. That request is consumed when the bus is available and the sequencer starts the block.

Once a block has started, low samples are ignored. The sequencer waits for a high sample on the pin, so a pin that stays low can never launch a second block. Acceptance reopens after the dead cycle, provided a high sample has been seen by then. If it has not, acceptance reopens on the edge that first samples the pin high. The process repeats until the programmed number of blocks has run, and then a sticky transfer-end flag rises.

Software-style control is a single write strobe. The strobe carries an enable value, the block count, the block length and the start addresses. Source and destination addresses each advance by one per byte moved.

Top module: `dreq_edge_seq`

## Requirements
- R1: After synchronous reset, all three cycle strobes, `req_held` and `xfer_end` are 0, and acceptance is closed: a low pin with `bus_avail` high produces no held request and no read strobe until an enabling write.
- R2: An enabling write (`en_wr`=1, `en_val`=1, `xfer_cnt`≠0) opens acceptance, but the pin level on the edge that captures that write is not taken. The first sample that counts is on the following edge.
- R3: While acceptance is open, a low pin sample sets `req_held` on that same edge. It stays set, whatever the pin does, until the block starts or the channel is stopped.
- R4: A block starts on the first edge where `req_held` and `bus_avail` are both 1. `req_held` clears on that edge, and `rd_stb` is 1 in the following cycle. While `bus_avail` is 0, the held request waits and no strobe rises.
- R5: A block is N read/write pairs, where N is `blk_len` captured at block start, and a value of 0 means 2^LW. Each pair is one `rd_stb` cycle presenting `src_addr`, then one `wr_stb` cycle presenting `dst_addr`. Both addresses step by +1 after each write. Exactly one `dead_stb` cycle follows the last write, then the sequencer idles.
- R6: From block start until acceptance reopens, low pin samples are ignored and `req_held` stays 0. The gap from request clear to the earliest new held request is therefore at least 2 cycles.
- R7: If the pin was sampled high on any edge from block start through the edge that ends the dead cycle, acceptance is open immediately after the dead cycle. Otherwise it stays closed until an edge samples the pin high, and a low sample on the next edge is then taken.
- R8: After `xfer_cnt` blocks, `xfer_end` rises on the edge that ends the last dead cycle and acceptance closes for good. An enabling write with `xfer_cnt`=0 raises `xfer_end` at once and opens nothing. Any enable write clears the flag otherwise.
- R9: A write with `en_val`=0, or a reset, aborts at once. On the next cycle all strobes are 0, `req_held` is 0 and acceptance is closed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| en_wr | input | 1 | Channel-control write strobe |
| en_val | input | 1 | Enable value carried by the write |
| req_n | input | 1 | External request pin, active low |
| bus_avail | input | 1 | Bus may be taken for a block |
| blk_len | input | LW | Bytes per block (0 = 2^LW) |
| xfer_cnt | input | CW | Blocks per transfer, captured by the write |
| src_base | input | AW | Source start address, captured by the write |
| dst_base | input | AW | Destination start address, captured by the write |
| rd_stb | output | 1 | Read cycle in progress |
| wr_stb | output | 1 | Write cycle in progress |
| dead_stb | output | 1 | Dead cycle in progress |
| src_addr | output | AW | Current source address |
| dst_addr | output | AW | Current destination address |
| req_held | output | 1 | A request is pending |
| xfer_end | output | 1 | Programmed block count has completed |

## Verification
Two events can land on one clock edge: the edge that ends the dead cycle and the first high sample of the pin. The bench holds the pin low through the read and write cycles. It then releases the pin during the dead cycle, so the dead-cycle exit edge is also the re-arming sample. It judges the outcome by driving the pin low again and requiring `req_held` to appear on the very next edge. This is one cycle earlier than the separate scenario where the pin rises only after the dead cycle.

// File: rtl/dreq_seq_pkg.sv
`timescale 1ns/1ps
package dreq_seq_pkg;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_READ  = 2'd1,
    PH_WRITE = 2'd2,
    PH_DEAD  = 2'd3
  } phase_e;

  typedef struct packed {
    logic restart;   // enable with a non-zero count
    logic stop;      // enable value 0
    logic empty_go;  // enable with a zero count
  } ctl_cmd_t;

endpackage

// File: rtl/dreq_accept.sv
`timescale 1ns/1ps
module dreq_accept
  import dreq_seq_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  ctl_cmd_t cmd,
  input  logic     start,
  input  logic     busy,
  input  logic     dead_end,
  input  logic     final_end,
  input  logic     req_n,
  output logic     acc_open,
  output logic     req_held
);

  logic hi_seen;
  logic wait_hi;
  logic kill;

  assign kill = cmd.stop | cmd.empty_go | final_end;

  always_ff @(posedge clk) begin
    if (rst || kill) begin
      acc_open <= 1'b0;
      req_held <= 1'b0;
      hi_seen  <= 1'b0;
      wait_hi  <= 1'b0;
    end else if (cmd.restart) begin
      acc_open <= 1'b1;
      req_held <= 1'b0;
      hi_seen  <= 1'b0;
      wait_hi  <= 1'b0;
    end else begin
      // pending request capture
      if (acc_open && !req_n) begin
        req_held <= 1'b1;
        acc_open <= 1'b0;
      end
      // activation consumes the request and starts edge re-arming
      if (start) begin
        req_held <= 1'b0;
        hi_seen  <= 1'b0;
      end
      if (busy && req_n && !dead_end) begin
        hi_seen <= 1'b1;
      end
      // dead cycle exit: reopen or wait for a high sample
      if (dead_end) begin
        if (hi_seen || req_n) begin
          acc_open <= 1'b1;
        end else begin
          wait_hi <= 1'b1;
        end
      end
      if (wait_hi && req_n) begin
        acc_open <= 1'b1;
        wait_hi  <= 1'b0;
      end
    end
  end

  AST_BUSY_NO_HOLD: assert property (@(posedge clk) disable iff (rst)
    busy |-> !req_held) else $error("held request during block"); // R6

  AST_START_CLEARS: assert property (@(posedge clk) disable iff (rst)
    start |=> !req_held) else $error("request not cleared"); // R4

  AST_CLEAR_GAP: assert property (@(posedge clk) disable iff (rst)
    $fell(req_held) |=> !req_held) else $error("request re-held too soon"); // R6

  AST_WAIT_BLOCKS: assert property (@(posedge clk) disable iff (rst)
    (wait_hi && !req_n && !cmd.restart) |=> !acc_open) else $error("reopened on low"); // R7

endmodule

// File: rtl/dreq_block_seq.sv
`timescale 1ns/1ps
module dreq_block_seq
  import dreq_seq_pkg::*;
#(
  parameter int LW = 8,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  ctl_cmd_t      cmd,
  input  logic          req_held,
  input  logic          bus_avail,
  input  logic [LW-1:0] blk_len,
  input  logic [CW-1:0] xfer_cnt,
  output phase_e        phase,
  output logic          start,
  output logic          busy,
  output logic          dead_end,
  output logic          final_end,
  output logic          wr_done,
  output logic          xfer_end
);

  localparam logic [LW-1:0] LEN_ONE = LW'(1);
  localparam logic [CW-1:0] CNT_ONE = CW'(1);

  phase_e        st;
  logic          en_q;
  logic [LW-1:0] bytes_left;
  logic [CW-1:0] blks_left;
  logic          any_cmd;

  assign any_cmd   = cmd.restart | cmd.stop | cmd.empty_go;
  assign phase     = st;
  assign busy      = (st != PH_IDLE);
  assign start     = en_q && (st == PH_IDLE) && req_held && bus_avail && !any_cmd;
  assign dead_end  = (st == PH_DEAD) && !any_cmd;
  assign final_end = dead_end && (blks_left == CNT_ONE);
  assign wr_done   = (st == PH_WRITE) && !any_cmd;

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= PH_IDLE;
      en_q       <= 1'b0;
      bytes_left <= '0;
      blks_left  <= '0;
      xfer_end   <= 1'b0;
    end else if (cmd.restart) begin
      st        <= PH_IDLE;
      en_q      <= 1'b1;
      blks_left <= xfer_cnt;
      xfer_end  <= 1'b0;
    end else if (cmd.stop) begin
      st       <= PH_IDLE;
      en_q     <= 1'b0;
      xfer_end <= 1'b0;
    end else if (cmd.empty_go) begin
      st       <= PH_IDLE;
      en_q     <= 1'b0;
      xfer_end <= 1'b1;
    end else begin
      unique case (st)
        PH_IDLE: begin
          if (start) begin
            st         <= PH_READ;
            bytes_left <= blk_len;
          end
        end
        PH_READ: st <= PH_WRITE;
        PH_WRITE: begin
          if (bytes_left == LEN_ONE) begin
            st <= PH_DEAD;
          end else begin
            bytes_left <= bytes_left - LEN_ONE;
            st         <= PH_READ;
          end
        end
        PH_DEAD: begin
          st <= PH_IDLE;
          if (blks_left == CNT_ONE) begin
            en_q     <= 1'b0;
            xfer_end <= 1'b1;
          end else begin
            blks_left <= blks_left - CNT_ONE;
          end
        end
        default: st <= PH_IDLE;
      endcase
    end
  end

  AST_END_STICKY: assert property (@(posedge clk) disable iff (rst)
    (xfer_end && !any_cmd) |=> xfer_end) else $error("end flag dropped"); // R8

  AST_NO_START_AFTER_END: assert property (@(posedge clk) disable iff (rst)
    xfer_end |-> !start) else $error("block after end"); // R8

endmodule

// File: rtl/dreq_addr_gen.sv
`timescale 1ns/1ps
module dreq_addr_gen #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic          step,
  input  logic [AW-1:0] src_base,
  input  logic [AW-1:0] dst_base,
  output logic [AW-1:0] src_addr,
  output logic [AW-1:0] dst_addr
);

  localparam int NPTR = 2;

  logic [AW-1:0] base_v [NPTR];
  logic [AW-1:0] ptr_q  [NPTR];

  assign base_v[0] = src_base;
  assign base_v[1] = dst_base;

  for (genvar g = 0; g < NPTR; g++) begin : g_ptr
    always_ff @(posedge clk) begin
      if (rst) begin
        ptr_q[g] <= '0;
      end else if (load) begin
        ptr_q[g] <= base_v[g];
      end else if (step) begin
        ptr_q[g] <= ptr_q[g] + AW'(1);
      end
    end
  end

  assign src_addr = ptr_q[0];
  assign dst_addr = ptr_q[1];

  AST_SRC_STEP: assert property (@(posedge clk) disable iff (rst)
    (step && !load) |=> (src_addr == $past(src_addr) + AW'(1))) else $error("src step"); // R5

  AST_DST_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!step && !load) |=> $stable(dst_addr)) else $error("dst moved"); // R5

endmodule

// File: rtl/dreq_edge_seq.sv
`timescale 1ns/1ps
module dreq_edge_seq
  import dreq_seq_pkg::*;
#(
  parameter int AW = 16,
  parameter int LW = 8,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en_wr,
  input  logic          en_val,
  input  logic          req_n,
  input  logic          bus_avail,
  input  logic [LW-1:0] blk_len,
  input  logic [CW-1:0] xfer_cnt,
  input  logic [AW-1:0] src_base,
  input  logic [AW-1:0] dst_base,
  output logic          rd_stb,
  output logic          wr_stb,
  output logic          dead_stb,
  output logic [AW-1:0] src_addr,
  output logic [AW-1:0] dst_addr,
  output logic          req_held,
  output logic          xfer_end
);

  ctl_cmd_t cmd;
  phase_e   phase;
  logic     start, busy, dead_end, final_end, wr_done, acc_open;
  logic     cnt_zero;

  assign cnt_zero    = (xfer_cnt == '0);
  assign cmd.restart  = en_wr && en_val && !cnt_zero;
  assign cmd.stop     = en_wr && !en_val;
  assign cmd.empty_go = en_wr && en_val && cnt_zero;

  dreq_accept u_accept (
    .clk       (clk),
    .rst       (rst),
    .cmd       (cmd),
    .start     (start),
    .busy      (busy),
    .dead_end  (dead_end),
    .final_end (final_end),
    .req_n     (req_n),
    .acc_open  (acc_open),
    .req_held  (req_held)
  );

  dreq_block_seq #(.LW(LW), .CW(CW)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .cmd       (cmd),
    .req_held  (req_held),
    .bus_avail (bus_avail),
    .blk_len   (blk_len),
    .xfer_cnt  (xfer_cnt),
    .phase     (phase),
    .start     (start),
    .busy      (busy),
    .dead_end  (dead_end),
    .final_end (final_end),
    .wr_done   (wr_done),
    .xfer_end  (xfer_end)
  );

  dreq_addr_gen #(.AW(AW)) u_addr (
    .clk      (clk),
    .rst      (rst),
    .load     (cmd.restart),
    .step     (wr_done),
    .src_base (src_base),
    .dst_base (dst_base),
    .src_addr (src_addr),
    .dst_addr (dst_addr)
  );

  assign rd_stb   = (phase == PH_READ);
  assign wr_stb   = (phase == PH_WRITE);
  assign dead_stb = (phase == PH_DEAD);

  AST_READ_THEN_WRITE: assert property (@(posedge clk) disable iff (rst)
    (rd_stb && !en_wr) |=> wr_stb) else $error("read not followed by write"); // R5

  AST_DEAD_SINGLE: assert property (@(posedge clk) disable iff (rst)
    dead_stb |=> !(rd_stb || wr_stb || dead_stb)) else $error("dead cycle too long"); // R5

  AST_END_CLOSED: assert property (@(posedge clk) disable iff (rst)
    xfer_end |-> !acc_open) else $error("acceptance open after end"); // R8

  AST_STOP_QUIET: assert property (@(posedge clk) disable iff (rst)
    (en_wr && !en_val) |=> !(rd_stb || wr_stb || dead_stb || req_held)) else $error("stop"); // R9

endmodule

// File: tb/dreq_edge_seq_tb.sv
`timescale 1ns/1ps
module dreq_edge_seq_tb;

  logic        clk = 1'b0;
  logic        rst, en_wr, en_val, req_n, bus_avail;
  logic [7:0]  blk_len, xfer_cnt;
  logic [15:0] src_base, dst_base, src_addr, dst_addr;
  logic        rd_stb, wr_stb, dead_stb, req_held, xfer_end;
  int          n_chk = 0;
  int          n_fail = 0;

  always #2.5 clk = ~clk;

  dreq_edge_seq u_dut (
    .clk(clk), .rst(rst), .en_wr(en_wr), .en_val(en_val), .req_n(req_n),
    .bus_avail(bus_avail), .blk_len(blk_len), .xfer_cnt(xfer_cnt),
    .src_base(src_base), .dst_base(dst_base), .rd_stb(rd_stb), .wr_stb(wr_stb),
    .dead_stb(dead_stb), .src_addr(src_addr), .dst_addr(dst_addr),
    .req_held(req_held), .xfer_end(xfer_end)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1; en_wr = 1'b0; en_val = 1'b0; req_n = 1'b1; bus_avail = 1'b0;
    blk_len = 8'd1; xfer_cnt = 8'd1; src_base = 16'h0; dst_base = 16'h0;
    tick(); tick(); tick();
    rst = 1'b0;
  endtask

  task automatic en_write(input logic v, input logic [7:0] cnt);
    en_wr = 1'b1; en_val = v; xfer_cnt = cnt;
    tick();
    en_wr = 1'b0;
  endtask

  function automatic logic [31:0] strobes();
    return {29'd0, rd_stb, wr_stb, dead_stb};
  endfunction

  // expects the first read cycle to be visible now
  task automatic check_block(input int len, input int sb, input int db);
    for (int i = 0; i < len; i++) begin
      check("R5 read strobe", 32'(rd_stb), 32'd1);
      check("R5 source address", 32'(src_addr), 32'(sb + i));
      tick();
      check("R5 write strobe", 32'(wr_stb), 32'd1);
      check("R5 destination address", 32'(dst_addr), 32'(db + i));
      tick();
    end
    check("R5 dead strobe", 32'(dead_stb), 32'd1);
    tick();
    check("R5 idle after dead", strobes(), 32'd0);
  endtask

  task automatic t_reset();
    do_reset();
    check("R1 strobes after reset", strobes(), 32'd0);
    check("R1 held after reset", 32'(req_held), 32'd0);
    check("R1 end after reset", 32'(xfer_end), 32'd0);
    bus_avail = 1'b1; req_n = 1'b0;
    tick(); tick(); tick();
    check("R1 no accept without enable", 32'(req_held), 32'd0);
    check("R1 no read without enable", strobes(), 32'd0);
  endtask

  task automatic t_enable_and_hold();
    do_reset();
    blk_len = 8'd2; src_base = 16'h0100; dst_base = 16'h0200;
    req_n = 1'b0;
    en_write(1'b1, 8'd4);           // low on the enable edge only
    req_n = 1'b1;
    tick();
    check("R2 enable edge sample ignored", 32'(req_held), 32'd0);
    req_n = 1'b0;
    tick();
    check("R3 low sample held", 32'(req_held), 32'd1);
    req_n = 1'b1;
    tick(); tick(); tick();
    check("R3 held persists", 32'(req_held), 32'd1);
    check("R4 waits for bus", strobes(), 32'd0);
    bus_avail = 1'b1;
    tick();
    check("R4 held cleared at start", 32'(req_held), 32'd0);
    check_block(2, 'h100, 'h200);
    req_n = 1'b0;
    tick();
    check("R7 reopened after high during block", 32'(req_held), 32'd1);
  endtask

  task automatic t_long_block();
    int nr = 0;
    int nw = 0;
    int guard = 0;
    do_reset();
    blk_len = 8'd0; src_base = 16'h1000; dst_base = 16'h3000; bus_avail = 1'b1;
    en_write(1'b1, 8'd1);
    req_n = 1'b0; tick(); req_n = 1'b1; tick();
    while (!dead_stb && guard < 600) begin
      nr += int'(rd_stb);
      nw += int'(wr_stb);
      tick();
      guard++;
    end
    check("R5 zero length reads 256", 32'(nr), 32'd256);
    check("R5 zero length writes 256", 32'(nw), 32'd256);
    check("R5 source after block", 32'(src_addr), 32'h1100);
    check("R5 destination after block", 32'(dst_addr), 32'h3100);
    tick();
    check("R8 end after single block", 32'(xfer_end), 32'd1);
  endtask

  task automatic t_held_low();
    do_reset();
    blk_len = 8'd1; src_base = 16'h0040; dst_base = 16'h0080; bus_avail = 1'b1;
    en_write(1'b1, 8'd4);
    req_n = 1'b0;
    tick();
    check("R3 held", 32'(req_held), 32'd1);
    tick();
    check("R6 cleared at start", 32'(req_held), 32'd0);
    check("R4 read after start", 32'(rd_stb), 32'd1);
    tick();
    check("R6 low ignored in write", 32'(req_held), 32'd0);
    tick();
    check("R6 low ignored in dead", 32'(req_held), 32'd0);
    for (int i = 0; i < 5; i++) tick();
    check("R7 stays closed while low", 32'(req_held), 32'd0);
    check("R7 no second block", strobes(), 32'd0);
    req_n = 1'b1;
    tick();
    check("R7 high sample alone holds nothing", 32'(req_held), 32'd0);
    req_n = 1'b0;
    tick();
    check("R7 accepted after late high", 32'(req_held), 32'd1);
  endtask

  task automatic t_same_edge();
    do_reset();
    blk_len = 8'd1; bus_avail = 1'b1;
    en_write(1'b1, 8'd4);
    req_n = 1'b0;
    tick(); tick();
    check("R4 read started", 32'(rd_stb), 32'd1);
    tick(); tick();
    check("R5 dead reached", 32'(dead_stb), 32'd1);
    check("R6 none held in dead", 32'(req_held), 32'd0);
    req_n = 1'b1;                   // first high sample is the dead exit edge
    tick();
    check("R7 idle after dead", strobes(), 32'd0);
    req_n = 1'b0;
    tick();
    check("R7 accepted on edge after dead exit", 32'(req_held), 32'd1);
  endtask

  task automatic t_count_end();
    do_reset();
    blk_len = 8'd1; bus_avail = 1'b1;
    en_write(1'b1, 8'd2);
    for (int b = 0; b < 2; b++) begin
      req_n = 1'b0; tick(); req_n = 1'b1;
      tick(); tick(); tick(); tick();
      check("R8 end flag per block", 32'(xfer_end), (b == 1) ? 32'd1 : 32'd0);
    end
    req_n = 1'b0; tick(); tick();
    check("R8 no hold after end", 32'(req_held), 32'd0);
    check("R8 no block after end", strobes(), 32'd0);
    req_n = 1'b1;
    en_write(1'b1, 8'd3);
    check("R8 enable clears end", 32'(xfer_end), 32'd0);
    en_write(1'b1, 8'd0);
    check("R8 zero count ends at once", 32'(xfer_end), 32'd1);
    req_n = 1'b0; tick();
    check("R8 zero count opens nothing", 32'(req_held), 32'd0);
  endtask

  task automatic t_abort();
    do_reset();
    blk_len = 8'd4; bus_avail = 1'b1;
    en_write(1'b1, 8'd4);
    req_n = 1'b0; tick(); tick(); tick();
    check("R9 block running", 32'(wr_stb), 32'd1);
    en_write(1'b0, 8'd4);
    check("R9 strobes stop", strobes(), 32'd0);
    tick(); tick();
    check("R9 closed after stop", 32'(req_held), 32'd0);
    bus_avail = 1'b0; req_n = 1'b1;
    en_write(1'b1, 8'd4);
    req_n = 1'b0; tick();
    check("R3 held before stop", 32'(req_held), 32'd1);
    en_write(1'b0, 8'd4);
    check("R9 stop drops held", 32'(req_held), 32'd0);
    en_write(1'b1, 8'd4);
    tick();
    check("R3 held again", 32'(req_held), 32'd1);
    rst = 1'b1; tick(); rst = 1'b0;
    check("R9 reset drops held", 32'(req_held), 32'd0);
    tick();
    check("R9 closed after reset", 32'(req_held), 32'd0);
  endtask

  initial begin
    #1000000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    t_reset();
    t_enable_and_hold();
    t_long_block();
    t_held_low();
    t_same_edge();
    t_count_end();
    t_abort();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule